// File: doc/BRIEF.md
# Serial Receive Character Queue with Hysteretic RTS

This block sits between a serial receiver's character deserializer and a 32-bit host register bus. Each received 8-bit character is pushed into a circular queue. The host takes characters out by reading the receive-holding address. A byte-wide read always takes one character. A word-wide read takes up to four characters when the port is in multiple-character mode, packed oldest-first from the low byte upwards. It takes one character in single-character mode. Single-character mode applies whenever 9-bit characters are enabled or the protocol mode selects one of the framed bus protocols (codes 1 to 3).

The request-to-send output is driven by a two-state machine with hysteresis on queue occupancy. RTS_GO drives RTS low and asks the peer to send. RTS_STOP drives RTS high and asks the peer to pause. Transition STOP_ON_FILL (RTS_GO to RTS_STOP) fires when occupancy moves from below the high threshold to at or above it. Transition GO_ON_DRAIN (RTS_STOP to RTS_GO) fires when occupancy moves from above the low threshold to at or below it. Transition GO_ON_DISABLE (any state to RTS_GO) fires whenever threshold control is disabled. When none of these fires, the state holds. Software must program the low threshold no higher than the high threshold.

A character that arrives while the queue is full is discarded and raises a sticky overrun flag. The flag is cleared by pulsing the clear input.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset, level is 0, rts is 0, overrun is 0 and rd_data is 0.
- R2: A pulse on rx_valid with level below DEPTH stores rx_char behind the characters already held, and level rises by one at the next edge.
- R3: A read with rd_en=1 and rd_word=0 while level>0 removes exactly one character. The oldest character appears in rd_data[7:0], with rd_data[31:8]=0, in the cycle after the read edge.
- R4: In multiple-character mode (nine_bit_en=0 and proto_mode=0), a read with rd_word=1 removes min(4, level) characters. The oldest character goes to rd_data[7:0] and the next ones to successively higher bytes. Bytes with no character read as 0.
- R5: In single-character mode (nine_bit_en=1 or proto_mode in 1..3), a read with rd_word=1 removes one character and returns it in rd_data[7:0] with the upper bytes 0.
- R6: rx_valid while level equals DEPTH leaves the stored characters and level unchanged and sets overrun. Overrun stays set until ovr_clr=1 in a cycle with no new drop, and a drop in the same cycle as ovr_clr takes priority.
- R7: With rts_ctrl_en=1, a level change from below hi_thr to at least hi_thr drives rts to 1 at the same edge that updates level.
- R8: With rts_ctrl_en=1, a level change from above lo_thr to at most lo_thr drives rts to 0 at the same edge. Any other level change leaves rts unchanged.
- R9: With rts_ctrl_en=0, rts is 0 from the next edge. Re-enabling while level is already at or above hi_thr leaves rts at 0 until an upward crossing occurs.
- R10: A read of an empty queue returns rd_data=0 and leaves level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_char | input | 8 | Received character |
| nine_bit_en | input | 1 | 9-bit character mode; forces single-character mode |
| proto_mode | input | 2 | Protocol mode; 0 is asynchronous, 1..3 force single-character mode |
| rts_ctrl_en | input | 1 | Enables threshold-driven RTS |
| lo_thr | input | $clog2(DEPTH)+1 | Low occupancy threshold |
| hi_thr | input | $clog2(DEPTH)+1 | High occupancy threshold |
| rd_en | input | 1 | Read of the receive-holding address |
| rd_word | input | 1 | Access size: 1 is 32-bit, 0 is 8-bit |
| ovr_clr | input | 1 | Clears the overrun flag when 1 |
| rd_data | output | 32 | Registered read data |
| rts | output | 1 | Request-to-send; 1 asks the peer to stop |
| level | output | $clog2(DEPTH)+1 | Characters currently held |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is re-enabling RTS control while occupancy already sits above the high threshold. No crossing has happened, so RTS must stay low even though the level looks "too high". The stimulus fills the queue past the threshold with control on, switches control off and back on, and pushes further. It then drains the queue below the low threshold and refills it, to show that only a true upward crossing raises RTS again. The hold band between the thresholds is exercised with byte-wide reads and single pushes. These change the level one step at a time, so every intermediate level is observed.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic {
        RTS_GO   = 1'b0,
        RTS_STOP = 1'b1
    } rts_state_e;

    localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic [2:0]    pop_cnt,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt,
    output logic [31:0]   peek
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign level_nxt = level + LW'(push) - LW'(pop_cnt);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            level  <= level_nxt;
        end
    end

    for (genvar gi = 0; gi < rxf_pkg::BYTES_PER_WORD; gi++) begin : g_peek
        logic [AW-1:0] idx;
        assign idx = rd_ptr + AW'(gi);
        assign peek[8*gi +: 8] = mem[idx];
    end
endmodule

// File: rtl/rxf_rts_fsm.sv
module rxf_rts_fsm #(
    parameter int unsigned LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] lvl_cur,
    input  logic [LW-1:0] lvl_nxt,
    input  logic [LW-1:0] lo_thr,
    input  logic [LW-1:0] hi_thr,
    output logic          rts
);
    import rxf_pkg::*;

    rts_state_e state, state_nxt;
    logic up_cross, down_cross;

    assign up_cross   = (lvl_cur < hi_thr) && (lvl_nxt >= hi_thr);
    assign down_cross = (lvl_cur > lo_thr) && (lvl_nxt <= lo_thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_GO;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (!en) begin
            state_nxt = RTS_GO;
        end else begin
            unique case (state)
                RTS_GO:   if (up_cross)   state_nxt = RTS_STOP;
                RTS_STOP: if (down_cross) state_nxt = RTS_GO;
                default:                  state_nxt = RTS_GO;
            endcase
        end
    end

    always_comb begin
        rts = (state == RTS_STOP);
    end
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_char,
    input  logic          nine_bit_en,
    input  logic [1:0]    proto_mode,
    input  logic          rts_ctrl_en,
    input  logic [LW-1:0] lo_thr,
    input  logic [LW-1:0] hi_thr,
    input  logic          rd_en,
    input  logic          rd_word,
    input  logic          ovr_clr,
    output logic [31:0]   rd_data,
    output logic          rts,
    output logic [LW-1:0] level,
    output logic          overrun
);
    logic          full, accept, drop, multi;
    logic [2:0]    pop_cnt;
    logic [LW-1:0] level_nxt;
    logic [31:0]   peek, packed_word;

    assign full   = (level == LW'(DEPTH));
    assign accept = rx_valid && !full;
    assign drop   = rx_valid && full;
    assign multi  = !nine_bit_en && (proto_mode == 2'd0);

    always_comb begin
        pop_cnt = 3'd0;
        if (rd_en && level != '0) begin
            if (rd_word && multi)
                pop_cnt = (level >= LW'(4)) ? 3'd4 : 3'(level);
            else
                pop_cnt = 3'd1;
        end
    end

    for (genvar gb = 0; gb < rxf_pkg::BYTES_PER_WORD; gb++) begin : g_mask
        assign packed_word[8*gb +: 8] = (3'(gb) < pop_cnt) ? peek[8*gb +: 8] : 8'h00;
    end

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .din       (rx_char),
        .pop_cnt   (pop_cnt),
        .level     (level),
        .level_nxt (level_nxt),
        .peek      (peek)
    );

    rxf_rts_fsm #(.LW(LW)) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rts_ctrl_en),
        .lvl_cur (level),
        .lvl_nxt (level_nxt),
        .lo_thr  (lo_thr),
        .hi_thr  (hi_thr),
        .rts     (rts)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            overrun <= 1'b0;
        end else begin
            if (rd_en) rd_data <= packed_word;
            if (drop)         overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          nine_bit_en,
    input logic [1:0]    proto_mode,
    input logic          rts_ctrl_en,
    input logic [LW-1:0] lo_thr,
    input logic [LW-1:0] hi_thr,
    input logic          rd_en,
    input logic          rd_word,
    input logic          ovr_clr,
    input logic          rts,
    input logic [LW-1:0] level,
    input logic          overrun
);
    logic multi_m;
    assign multi_m = !nine_bit_en && (proto_mode == 2'd0);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && level == LW'(DEPTH) |=> overrun);

    // R6
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr && !(rx_valid && level == LW'(DEPTH)) |=> !overrun);

    // R7
    rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> level >= hi_thr);

    // R8
    rts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> (level <= lo_thr) || !$past(rts_ctrl_en));

    // R9
    rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_ctrl_en |=> !rts);

    // R3
    byte_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_word && level != '0 && !rx_valid |=> level == $past(level) - LW'(1));

    // R4
    word_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_word && multi_m && level >= LW'(4) && !rx_valid |=> level == $past(level) - LW'(4));

    // R5
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_word && !multi_m && level != '0 && !rx_valid |=> level == $past(level) - LW'(1));
endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .nine_bit_en (nine_bit_en),
    .proto_mode  (proto_mode),
    .rts_ctrl_en (rts_ctrl_en),
    .lo_thr      (lo_thr),
    .hi_thr      (hi_thr),
    .rd_en       (rd_en),
    .rd_word     (rd_word),
    .ovr_clr     (ovr_clr),
    .rts         (rts),
    .level       (level),
    .overrun     (overrun)
);

// File: tb/test_rx_fifo_rts.sv
module test_rx_fifo_rts;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned LW = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_char = '0;
    logic          nine_bit_en = 1'b0;
    logic [1:0]    proto_mode = 2'd0;
    logic          rts_ctrl_en = 1'b0;
    logic [LW-1:0] lo_thr = '0;
    logic [LW-1:0] hi_thr = LW'(DEPTH);
    logic          rd_en = 1'b0;
    logic          rd_word = 1'b0;
    logic          ovr_clr = 1'b0;
    logic [31:0]   rd_data;
    logic          rts;
    logic [LW-1:0] level;
    logic          overrun;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    logic [7:0]  model_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rts_m = 1'b0;

    always #10 clk = ~clk;

    rx_fifo_rts #(.DEPTH(DEPTH)) i_rx_fifo_rts (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .nine_bit_en(nine_bit_en), .proto_mode(proto_mode), .rts_ctrl_en(rts_ctrl_en),
        .lo_thr(lo_thr), .hi_thr(hi_thr), .rd_en(rd_en), .rd_word(rd_word),
        .ovr_clr(ovr_clr), .rd_data(rd_data), .rts(rts), .level(level), .overrun(overrun)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void rts_update(int old_l, int new_l);
        if (!rts_ctrl_en) rts_m = 1'b0;
        else if (old_l < int'(hi_thr) && new_l >= int'(hi_thr)) rts_m = 1'b1;
        else if (old_l > int'(lo_thr) && new_l <= int'(lo_thr)) rts_m = 1'b0;
    endfunction

    // monitor: compares registered read data one cycle after each read edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic push_char(logic [7:0] c, string req);
        int old_l = model_q.size();
        @(negedge clk);
        rx_valid = 1'b1;
        rx_char  = c;
        if (old_l < DEPTH) model_q.push_back(c);
        rts_update(old_l, model_q.size());
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " level"}, 32'(level), 32'(model_q.size()));
        check({req, " rts"}, 32'(rts), 32'(rts_m));
    endtask

    task automatic read_fifo(logic word, string req);
        int old_l = model_q.size();
        int n;
        logic multi = !nine_bit_en && proto_mode == 2'd0;
        logic [31:0] e = '0;
        @(negedge clk);
        n = (old_l == 0) ? 0 : ((word && multi) ? ((old_l >= 4) ? 4 : old_l) : 1);
        for (int i = 0; i < n; i++) e[8*i +: 8] = model_q.pop_front();
        exp_q.push_back(e);
        tag_q.push_back({req, " rd_data"});
        rts_update(old_l, model_q.size());
        rd_en   = 1'b1;
        rd_word = word;
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " level"}, 32'(level), 32'(model_q.size()));
        check({req, " rts"}, 32'(rts), 32'(rts_m));
    endtask

    task automatic set_en(logic v, string req);
        @(negedge clk);
        rts_ctrl_en = v;
        if (!v) rts_m = 1'b0;
        @(negedge clk);
        check({req, " rts after enable change"}, 32'(rts), 32'(rts_m));
    endtask

    task automatic drain();
        while (model_q.size() > 0) read_fifo(1'b1, "R4 drain");
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 level", 32'(level), 0);
        check("R1 rts", 32'(rts), 0);
        check("R1 overrun", 32'(overrun), 0);
        check("R1 rd_data", rd_data, 0);

        // R2 ordered storage
        for (int i = 1; i <= 5; i++) push_char(8'(8'h10 + i), "R2 push");
        // R3 byte read
        read_fifo(1'b0, "R3 byte read");
        // R4 full packed word
        read_fifo(1'b1, "R4 word read");
        // R4 partial word
        push_char(8'hA0, "R2 push");
        push_char(8'hA1, "R2 push");
        read_fifo(1'b1, "R4 partial word");
        // R10 empty read
        read_fifo(1'b1, "R10 empty word");
        read_fifo(1'b0, "R10 empty byte");

        // R5 single-character mode
        push_char(8'hC1, "R2 push");
        push_char(8'hC2, "R2 push");
        push_char(8'hC3, "R2 push");
        nine_bit_en = 1'b1;
        read_fifo(1'b1, "R5 nine-bit word");
        nine_bit_en = 1'b0;
        proto_mode  = 2'd2;
        read_fifo(1'b1, "R5 proto word");
        proto_mode = 2'd0;
        read_fifo(1'b0, "R3 byte read");

        // R6 overrun
        for (int i = 0; i < DEPTH; i++) push_char(8'(8'h40 + i), "R2 fill");
        check("R6 no overrun yet", 32'(overrun), 0);
        push_char(8'hEE, "R6 drop");
        check("R6 overrun set", 32'(overrun), 1);
        push_char(8'hEF, "R6 drop");
        read_fifo(1'b0, "R6 oldest kept");
        check("R6 overrun sticky", 32'(overrun), 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        check("R6 overrun cleared", 32'(overrun), 0);
        drain();

        // R7 / R8 hysteresis
        lo_thr = LW'(2);
        hi_thr = LW'(6);
        set_en(1'b1, "R9");
        for (int i = 0; i < 6; i++) push_char(8'(8'h60 + i), "R7 rise");
        check("R7 rts high at threshold", 32'(rts), 1);
        read_fifo(1'b0, "R8 hold");
        read_fifo(1'b0, "R8 hold");
        read_fifo(1'b0, "R8 hold");
        check("R8 rts holds in band", 32'(rts), 1);
        read_fifo(1'b0, "R8 fall");
        check("R8 rts low at threshold", 32'(rts), 0);
        for (int i = 0; i < 3; i++) push_char(8'(8'h70 + i), "R8 hold low");
        check("R8 rts low in band", 32'(rts), 0);

        // R9 disable / re-enable above threshold
        for (int i = 0; i < 3; i++) push_char(8'(8'h78 + i), "R7 rise");
        check("R7 rts high", 32'(rts), 1);
        set_en(1'b0, "R9 disable");
        set_en(1'b1, "R9 re-enable above hi");
        push_char(8'h7F, "R9 no crossing");
        check("R9 rts stays low", 32'(rts), 0);
        while (model_q.size() > 2) read_fifo(1'b0, "R8 drain");
        for (int i = 0; i < 4; i++) push_char(8'(8'h90 + i), "R9 recross");
        check("R9 rts rises after true crossing", 32'(rts), 1);
        drain();

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule